// File: doc/BRIEF.md
# Phase Lock Detector for a Digital PLL

This block decides whether a digital PLL is in lock by watching the signed phase-error samples that the phase detector produces. Each valid sample is turned into a magnitude, with the most negative code clipped to the largest positive value. The magnitude is then compared with a programmable threshold. A sample is in range when its magnitude does not exceed the threshold. Lock is declared once in-range samples have continued without a break for a long dwell. Lock is dropped once out-of-range samples have continued for a dwell that is 256 times shorter. Both dwells come from a single interval setting.

Time is measured with a sub-tick strobe supplied from outside, one pulse every 15.625 µs (4 ms / 256). The interval setting counts in 4 ms units, so reaching lock takes interval × 256 sub-ticks and losing it takes interval sub-ticks. A run of samples on the side that would cause the pending transition starts a timer. The timer counts sub-ticks while the run lasts. The transition takes effect on the first qualifying sample that arrives once the timer has reached its target. A host writes and reads the threshold and the interval over a plain address/data bus.

Top module: `dpll_lock_detect`

## Requirements
- R1: After reset `locked` is 0, no dwell is running, the threshold reads 0x000F and the interval reads 0x2C00.
- R2: A cycle with `cfg_wr` high writes `cfg_wdata` to the threshold when `cfg_addr` is 0x0047 and to the interval when it is 0x0048. `cfg_rdata` returns, in the same cycle, the register selected by `cfg_addr`. It returns 0 for any other address, and writes to other addresses change nothing.
- R3: The magnitude of `ph_err` (16-bit two's complement) is its absolute value, except that 0x8000 yields 0x7FFF.
- R4: A sample is in range when its magnitude is less than or equal to the threshold, and out of range when the magnitude is strictly greater.
- R5: While unlocked, `locked` rises on the clock edge of an in-range sample when in-range samples have run without a break and at least interval × 256 sub-ticks were counted since the first of them.
- R6: While locked, `locked` falls on the clock edge of an out-of-range sample when out-of-range samples have run without a break and at least interval sub-ticks were counted since the first of them.
- R7: A sample on the opposite side clears the running dwell, and counting restarts from zero with the next qualifying sample.
- R8: With an interval of 0, the first qualifying sample toggles `locked`.
- R9: A configuration write to either register clears both dwells and leaves `locked` unchanged. A sample presented in the same cycle as such a write is discarded.
- R10: A sub-tick arriving in the same cycle as a sample is counted after that sample is judged. It is counted only when the sample continues a run that is already going, and not when the sample starts a new run.
- R11: While `ph_valid` is low the phase input is ignored, and `locked` changes only on the edge that takes a valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_valid | input | 1 | Marks a new phase-error sample |
| ph_err | input | 16 | Signed phase error |
| tick | input | 1 | Sub-tick strobe, one per 15.625 µs |
| cfg_wr | input | 1 | Host write strobe |
| cfg_addr | input | 16 | Host register address |
| cfg_wdata | input | 16 | Host write data |
| cfg_rdata | output | 16 | Host read data for `cfg_addr` |
| locked | output | 1 | Lock status |

## Verification
The two events that can coincide are a sub-tick and the arrival of a sample. The bench drives both in the same cycle at the point where the gain-lock timer is one sub-tick short of its target. It judges from `locked`: it stays low on that sample and rises on the next sample, which carries no sub-tick. The bench also places a sub-tick on the sample that opens a run and shows that this sub-tick is not counted. It pairs a sample with a configuration write and confirms the sample is discarded.

// File: rtl/dpll_lock_detect.sv
module dpll_lock_detect #(
  parameter int unsigned PH_W     = 16,
  parameter int unsigned CFG_W    = 16,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DIV_LOG2 = 8,
  parameter int unsigned THR_ADDR = 'h0047,
  parameter int unsigned INT_ADDR = 'h0048,
  parameter int unsigned THR_INIT = 'h000F,
  parameter int unsigned INT_INIT = 'h2C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph_valid,
  input  logic [PH_W-1:0]   ph_err,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              locked
);
  localparam int unsigned TMR_W = CFG_W + DIV_LOG2;
  localparam int unsigned CMP_W = (PH_W > CFG_W) ? PH_W : CFG_W;
  localparam logic [PH_W-1:0] PH_MIN = {1'b1, {(PH_W-1){1'b0}}};
  localparam logic [PH_W-1:0] PH_MAX = ~PH_MIN;
  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(THR_ADDR);
  localparam logic [ADDR_W-1:0] A_INT = ADDR_W'(INT_ADDR);

  logic [CFG_W-1:0] thr_q, int_q;
  logic [TMR_W-1:0] tmr_q;
  logic             run_q;

  logic [PH_W-1:0]  mag;
  logic [TMR_W-1:0] target, tmr_inc;
  logic             in_rng, qual, reached, hit_thr, hit_int;

  assign mag     = !ph_err[PH_W-1] ? ph_err :
                   (ph_err == PH_MIN) ? PH_MAX : (~ph_err + {{(PH_W-1){1'b0}}, 1'b1});
  assign in_rng  = CMP_W'(mag) <= CMP_W'(thr_q);
  assign qual    = locked ? !in_rng : in_rng;
  assign target  = locked ? TMR_W'(int_q) : {int_q, {DIV_LOG2{1'b0}}};
  assign reached = tmr_q >= target;
  assign tmr_inc = (&tmr_q) ? tmr_q : tmr_q + {{(TMR_W-1){1'b0}}, 1'b1};

  assign hit_thr = cfg_wr && (cfg_addr == A_THR);
  assign hit_int = cfg_wr && (cfg_addr == A_INT);

  assign cfg_rdata = (cfg_addr == A_THR) ? thr_q :
                     (cfg_addr == A_INT) ? int_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= CFG_W'(THR_INIT);
      int_q  <= CFG_W'(INT_INIT);
      tmr_q  <= '0;
      run_q  <= 1'b0;
      locked <= 1'b0;
    end else if (hit_thr || hit_int) begin
      if (hit_thr) thr_q <= cfg_wdata;
      if (hit_int) int_q <= cfg_wdata;
      tmr_q <= '0;
      run_q <= 1'b0;
    end else if (ph_valid) begin
      if (qual && reached) begin
        locked <= !locked;
        tmr_q  <= '0;
        run_q  <= 1'b0;
      end else if (qual) begin
        run_q <= 1'b1;
        tmr_q <= !run_q ? '0 : (tick ? tmr_inc : tmr_q);
      end else begin
        run_q <= 1'b0;
        tmr_q <= '0;
      end
    end else if (run_q && tick) begin
      tmr_q <= tmr_inc;
    end
  end
endmodule

module dpll_lock_detect_chk #(
  parameter int unsigned CFG_W    = 16,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned THR_ADDR = 'h0047,
  parameter int unsigned INT_ADDR = 'h0048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ph_valid,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic              locked,
  input logic [CFG_W-1:0]  thr_q,
  input logic [CFG_W-1:0]  int_q
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  wire wr_thr = cfg_wr && (cfg_addr == ADDR_W'(THR_ADDR));
  wire wr_int = cfg_wr && (cfg_addr == ADDR_W'(INT_ADDR));
  wire unmapped = (cfg_addr != ADDR_W'(THR_ADDR)) && (cfg_addr != ADDR_W'(INT_ADDR));

  a_r11_idle_holds_lock: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    !ph_valid |=> $stable(locked));
  a_r9_write_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (wr_thr || wr_int) |=> $stable(locked));
  a_r2_thr_write: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    wr_thr |=> (thr_q == $past(cfg_wdata)));
  a_r2_int_write: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    wr_int |=> (int_q == $past(cfg_wdata)));
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (cfg_rdata == '0));
endmodule

bind dpll_lock_detect dpll_lock_detect_chk #(
  .CFG_W(CFG_W), .ADDR_W(ADDR_W), .THR_ADDR(THR_ADDR), .INT_ADDR(INT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ph_valid(ph_valid), .cfg_wr(cfg_wr),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .locked(locked), .thr_q(thr_q), .int_q(int_q)
);

// File: tb/sim_dpll_lock_detect.sv
module sim_dpll_lock_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph_valid = 1'b0;
  logic [15:0] ph_err = '0;
  logic        tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        locked;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dpll_lock_detect u0 (
    .clk(clk), .rst_n(rst_n), .ph_valid(ph_valid), .ph_err(ph_err), .tick(tick),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .locked(locked)
  );

  // {threshold, phase sample, expected lock}; interval is 0 throughout
  localparam logic [32:0] VEC [0:11] = '{
    {16'd100,    16'h0032, 1'b1},
    {16'd100,    16'h0064, 1'b1},
    {16'd100,    16'hFF9B, 1'b0},
    {16'd100,    16'hFF9C, 1'b1},
    {16'd100,    16'h0065, 1'b0},
    {16'd100,    16'hFF9B, 1'b0},
    {16'h7FFF,   16'h8000, 1'b1},
    {16'h7FFE,   16'h7FFF, 1'b0},
    {16'h7FFE,   16'h8000, 1'b0},
    {16'h0000,   16'h0000, 1'b1},
    {16'h0000,   16'h0001, 1'b0},
    {16'h0000,   16'hFFFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic smp(input logic [15:0] p, input logic tk);
    @(negedge clk); ph_valid = 1'b1; ph_err = p; tick = tk;
    @(negedge clk); ph_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 lock", 32'(locked), 0);
    rd(16'h0047, d); chk("R1 thr", 32'(d), 32'h000F);
    rd(16'h0048, d); chk("R1 int", 32'(d), 32'h2C00);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 lock after release", 32'(locked), 0);

    // R3 R4 R8 table, interval 0
    wr(16'h0048, 16'h0000);
    for (int k = 0; k < 12; k++) begin
      wr(16'h0047, VEC[k][32:17]);
      smp(VEC[k][16:1], 1'b0);
      chk($sformatf("R4 R3 R8 row %0d", k), 32'(locked), 32'(VEC[k][0]));
    end

    // R2 readback and unmapped address
    wr(16'h0047, 16'd100);
    wr(16'h0048, 16'd1);
    wr(16'h0049, 16'h1234);
    rd(16'h0047, d); chk("R2 thr", 32'(d), 100);
    rd(16'h0048, d); chk("R2 int", 32'(d), 1);
    rd(16'h0049, d); chk("R2 unmapped", 32'(d), 0);

    // R5 gain dwell: 256 sub-ticks
    smp(16'd10, 1'b0);
    ticks(255);
    smp(16'd10, 1'b0); chk("R5 short", 32'(locked), 0);
    ticks(1);
    smp(16'd10, 1'b0); chk("R5 reached", 32'(locked), 1);

    // R6 lose dwell: 1 sub-tick
    smp(16'd500, 1'b0); chk("R6 start", 32'(locked), 1);
    smp(16'd500, 1'b0); chk("R6 no tick", 32'(locked), 1);
    ticks(1);
    smp(16'd500, 1'b0); chk("R6 reached", 32'(locked), 0);

    // R7 interruption clears the dwell
    smp(16'd10, 1'b0);
    ticks(200);
    smp(16'd500, 1'b0);
    smp(16'd10, 1'b0);
    ticks(200);
    smp(16'd10, 1'b0); chk("R7 no accumulate", 32'(locked), 0);
    ticks(56);
    smp(16'd10, 1'b0); chk("R7 fresh run", 32'(locked), 1);

    // R10 sub-tick coinciding with samples
    smp(16'd500, 1'b0); ticks(1); smp(16'd500, 1'b0);
    chk("R10 setup unlocked", 32'(locked), 0);
    smp(16'd10, 1'b1);
    ticks(255);
    smp(16'd10, 1'b1); chk("R10 judged before tick", 32'(locked), 0);
    smp(16'd10, 1'b0); chk("R10 tick counted after", 32'(locked), 1);

    // R9 write restarts dwell, keeps lock
    smp(16'd500, 1'b0);
    ticks(1);
    wr(16'h0047, 16'd100); chk("R9 lock kept", 32'(locked), 1);
    smp(16'd500, 1'b0); chk("R9 dwell restarted", 32'(locked), 1);
    ticks(1);
    smp(16'd500, 1'b0); chk("R9 then drops", 32'(locked), 0);

    // R9 sample in the same cycle as a write is discarded
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 16'h0048; cfg_wdata = 16'h0000;
    ph_valid = 1'b1; ph_err = 16'd10;
    @(negedge clk);
    cfg_wr = 1'b0; ph_valid = 1'b0;
    chk("R9 sample discarded", 32'(locked), 0);
    smp(16'd10, 1'b0); chk("R8 zero interval", 32'(locked), 1);

    // R11 input ignored without valid
    @(negedge clk); ph_err = 16'd500; tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0;
    chk("R11 ignored", 32'(locked), 1);
    smp(16'd500, 1'b0); chk("R11 valid acts", 32'(locked), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule